// File: doc/BRIEF.md
# UART Receive Queue with Programmable Threshold

This block buffers characters between a UART receive shifter and the host. Each character that the shifter assembles enters a 16-deep, 8-bit queue. The host takes the characters out in arrival order with a read strobe. The block raises a threshold flag when enough characters are waiting. The host can then drain them in one burst instead of servicing every character on its own.

The host writes an 8-bit control byte. Bit 0 turns queue mode on. Bit 1 requests a one-shot flush. Bits 7:6 choose one of four fixed thresholds. A write with bit 0 clear only turns queue mode off; the other bits of that byte are dropped. With queue mode off, the block acts as a single-character holding register. The flush bit clears itself, so a flush happens once per write that requests it. Any change of mode also flushes the stored characters. A timeout-qualify output tells an external character timer when characters are waiting in queue mode.

Top module: `rxq_top`

## Requirements
- R1: After reset the count is 0, `empty` is 1, `full`, `trig_hit`, `overrun` and `tmo_qual` are 0, `rd_data` is 0, and queue mode is off.
- R2: With queue mode off, the block holds at most one character. `full` is 1 whenever the count is 1, and `trig_hit` equals (count != 0).
- R3: A control write with bit 0 = 0 does not flush and does not change the threshold, even if bits 1 or 7:6 are set. If queue mode was already off, stored characters remain readable.
- R4: A control write with bit 0 = 1 turns queue mode on and loads bits 7:6 as the threshold: 00 selects 1, 01 selects 4, 10 selects 8, 11 selects 14. In queue mode, `trig_hit` is 1 exactly when count >= threshold.
- R5: A control write with bits 1 and 0 both set empties the queue at the second rising edge after the write. Pushes and pops at that edge are discarded. The flush happens once, and characters pushed afterwards are kept.
- R6: Characters leave in arrival order. A pop registers the oldest character on `rd_data` at the pop edge. In queue mode the count never exceeds 16.
- R7: A push while `full` is 1 is dropped: the count and the contents are unchanged, and `overrun` is 1 for the single cycle after that edge.
- R8: A pop while `empty` is 1 leaves `rd_data` and the count unchanged.
- R9: A push and a pop at the same edge on a queue that is neither empty nor full leave the count unchanged and keep the order.
- R10: `empty` is 1 exactly when the count is 0. `full` is 1 exactly when the count reaches the mode's capacity (16 in queue mode, 1 otherwise).
- R11: `tmo_qual` is 1 exactly when queue mode is on and the count is nonzero.
- R12: A write that changes bit 0 from its stored value flushes the queue in the same way as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte |
| push_valid | input | 1 | Character from the receive shifter is valid |
| push_data | input | 8 | Character from the receive shifter |
| pop_strobe | input | 1 | Host read strobe |
| rd_data | output | 8 | Last character read out |
| count | output | 5 | Characters held |
| trig_hit | output | 1 | Threshold reached (or data present when queue mode is off) |
| empty | output | 1 | No characters held |
| full | output | 1 | Capacity reached |
| overrun | output | 1 | One-cycle pulse after a dropped push |
| tmo_qual | output | 1 | Characters waiting in queue mode, for an external timer |

## Verification
A corrupted pointer or count shows up at the next pop as a wrong or out-of-order byte on `rd_data`. It also shows at once in `count`, `empty`, `full` and `trig_hit`, which are decoded from the count in the same cycle. A stuck flush request would clear characters pushed later, and the count would read zero one cycle after such a push. A wrong mode bit changes the capacity, so the second push into a holding register would either be accepted or flagged as an overrun.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned RXQ_DEPTH = 16;
    localparam int unsigned RXQ_WIDTH = 8;

    typedef enum logic [1:0] {
        LVL_ONE      = 2'b00,
        LVL_FOUR     = 2'b01,
        LVL_EIGHT    = 2'b10,
        LVL_FOURTEEN = 2'b11
    } lvl_sel_e;

    typedef struct packed {
        lvl_sel_e lvl;
        logic     on;
    } rxq_cfg_t;

    function automatic int unsigned lvl_bytes(lvl_sel_e s);
        case (s)
            LVL_ONE:   return 1;
            LVL_FOUR:  return 4;
            LVL_EIGHT: return 8;
            default:   return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output rxq_cfg_t   cfg_q,
    output logic       flush_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '{lvl: LVL_ONE, on: 1'b0};
            flush_q <= 1'b0;
        end else begin
            flush_q <= 1'b0;
            if (cfg_we) begin
                if (cfg_wdata[0]) begin
                    cfg_q.on  <= 1'b1;
                    cfg_q.lvl <= lvl_sel_e'(cfg_wdata[7:6]);
                    flush_q   <= cfg_wdata[1] | ~cfg_q.on;
                end else begin
                    // only the mode bit is taken; a mode change flushes
                    cfg_q.on  <= 1'b0;
                    flush_q   <= cfg_q.on;
                end
            end
        end
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             single,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full,
    output logic             overrun
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cap;
    logic             do_push, do_pop;

    assign cap     = single ? CW'(1) : CW'(DEPTH);
    assign empty   = (count == '0);
    assign full    = (count >= cap);
    assign do_push = push & ~full & ~flush;
    assign do_pop  = pop & ~empty & ~flush;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            rd_data <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= push & full & ~flush;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                count  <= '0;
            end else begin
                if (do_push) wr_ptr <= bump(wr_ptr);
                if (do_pop) begin
                    rd_ptr  <= bump(rd_ptr);
                    rd_data <= mem[rd_ptr];
                end
                case ({do_push, do_pop})
                    2'b10:   count <= count + 1'b1;
                    2'b01:   count <= count - 1'b1;
                    default: count <= count;
                endcase
            end
        end
    end

endmodule

// File: rtl/rxq_trig.sv
module rxq_trig
    import rxq_pkg::*;
#(
    parameter int unsigned CW = 5
) (
    input  rxq_cfg_t      cfg,
    input  logic [CW-1:0] count,
    output logic          trig_hit,
    output logic          tmo_qual
);

    logic [CW-1:0] level;
    logic          nonzero;

    assign level    = CW'(lvl_bytes(cfg.lvl));
    assign nonzero  = (count != '0);
    assign trig_hit = cfg.on ? (count >= level) : nonzero;
    assign tmo_qual = cfg.on & nonzero;

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int unsigned WIDTH = RXQ_WIDTH,
    parameter int unsigned DEPTH = RXQ_DEPTH,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    input  logic             push_valid,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_strobe,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    count,
    output logic             trig_hit,
    output logic             empty,
    output logic             full,
    output logic             overrun,
    output logic             tmo_qual
);

    rxq_cfg_t cfg_q;
    logic     flush_w;

    rxq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q),
        .flush_q   (flush_w)
    );

    rxq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_w),
        .single    (~cfg_q.on),
        .push      (push_valid),
        .push_data (push_data),
        .pop       (pop_strobe),
        .rd_data   (rd_data),
        .count     (count),
        .empty     (empty),
        .full      (full),
        .overrun   (overrun)
    );

    rxq_trig #(.CW(CW)) u_trig (
        .cfg      (cfg_q),
        .count    (count),
        .trig_hit (trig_hit),
        .tmo_qual (tmo_qual)
    );

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             push,
    input logic             pop,
    input logic             flush,
    input logic             cfg_on,
    input logic [CW-1:0]    count,
    input logic             full,
    input logic             empty,
    input logic             overrun,
    input logic             trig_hit,
    input logic [WIDTH-1:0] rd_data
);

    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    a_r2_single_cap: assert property (@(posedge clk) disable iff (rst)
        (!cfg_on && !flush) |-> (count <= CW'(1)));

    a_r7_drop_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (count == $past(count)));

    a_r7_overrun_flag: assert property (@(posedge clk) disable iff (rst)
        (full && push && !flush) |=> overrun);

    a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push && !flush) |=> ($stable(count) && $stable(rd_data)));

    a_r5_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

    a_r4_no_trig_when_empty: assert property (@(posedge clk) disable iff (rst)
        empty |-> !trig_hit);

endmodule

bind rxq_top rxq_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .push     (push_valid),
    .pop      (pop_strobe),
    .flush    (flush_w),
    .cfg_on   (cfg_q.on),
    .count    (count),
    .full     (full),
    .empty    (empty),
    .overrun  (overrun),
    .trig_hit (trig_hit),
    .rd_data  (rd_data)
);

// File: tb/rxq_top_tb_top.sv
module rxq_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop_strobe = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] count;
    logic       trig_hit, empty, full, overrun, tmo_qual;

    int checks = 0;
    int errors = 0;

    // scoreboard model
    logic [7:0] m_q[$];
    logic       m_en = 1'b0;
    logic [1:0] m_sel = 2'b00;
    logic       m_flush = 1'b0;
    logic       m_ovr = 1'b0;
    logic [7:0] m_rd = 8'h00;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rxq_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .push_valid (push_valid),
        .push_data  (push_data),
        .pop_strobe (pop_strobe),
        .rd_data    (rd_data),
        .count      (count),
        .trig_hit   (trig_hit),
        .empty      (empty),
        .full       (full),
        .overrun    (overrun),
        .tmo_qual   (tmo_qual)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int lvl(input logic [1:0] s);
        case (s)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    task automatic check_all(input string tag);
        int sz  = m_q.size();
        int cap = m_en ? 16 : 1;
        logic e_trig = m_en ? (sz >= lvl(m_sel)) : (sz != 0);
        check(count == 5'(sz), tag, "count", count, sz);
        check(rd_data == m_rd, tag, "rd_data", rd_data, m_rd);
        check(empty == (sz == 0), "R10", "empty", empty, sz == 0);
        check(full == (sz >= cap), "R10", "full", full, sz >= cap);
        check(trig_hit == e_trig, "R4", "trig_hit", trig_hit, e_trig);
        check(tmo_qual == (m_en && sz != 0), "R11", "tmo_qual", tmo_qual, m_en && sz != 0);
        check(overrun == m_ovr, "R7", "overrun", overrun, m_ovr);
    endtask

    // one clock cycle of stimulus, model update, then check at the falling edge
    task automatic step(input logic p, input logic [7:0] pd, input logic rd,
                        input logic w, input logic [7:0] wd, input string tag);
        int  cap;
        logic was_full, nf;
        push_valid = p; push_data = pd; pop_strobe = rd; cfg_we = w; cfg_wdata = wd;
        @(posedge clk);
        cap = m_en ? 16 : 1;
        was_full = (m_q.size() >= cap);
        nf = 1'b0;
        if (w) begin
            if (wd[0]) begin
                nf = wd[1] | ~m_en;
                m_en = 1'b1;
                m_sel = wd[7:6];
            end else begin
                nf = m_en;
                m_en = 1'b0;
            end
        end
        if (m_flush) begin
            m_q.delete();
            m_ovr = 1'b0;
        end else begin
            m_ovr = p & was_full;
            if (rd && m_q.size() > 0) m_rd = m_q.pop_front();
            if (p && !was_full) m_q.push_back(pd);
        end
        m_flush = nf;
        @(negedge clk);
        push_valid = 1'b0; pop_strobe = 1'b0; cfg_we = 1'b0;
        check_all(tag);
    endtask

    task automatic push1(input logic [7:0] d, input string tag);
        step(1'b1, d, 1'b0, 1'b0, 8'h00, tag);
    endtask
    task automatic pop1(input string tag);
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'h00, tag);
    endtask
    task automatic wr1(input logic [7:0] d, input string tag);
        step(1'b0, 8'h00, 1'b0, 1'b1, d, tag);
    endtask
    task automatic idle(input string tag);
        step(1'b0, 8'h00, 1'b0, 1'b0, 8'h00, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(count == 0, "R1", "count", count, 0);
        check(empty == 1'b1, "R1", "empty", empty, 1);
        check(full == 1'b0 && trig_hit == 1'b0, "R1", "full/trig", {full, trig_hit}, 0);
        check(overrun == 1'b0 && tmo_qual == 1'b0, "R1", "ovr/tmo", {overrun, tmo_qual}, 0);
        check(rd_data == 8'h00, "R1", "rd_data", rd_data, 0);

        // R2 holding-register mode
        push1(8'hA1, "R2");
        push1(8'hB2, "R2");
        idle("R2");
        pop1("R2");
        check(rd_data == 8'hA1, "R2", "held byte", rd_data, 8'hA1);

        // R8 pop on empty
        pop1("R8");
        pop1("R8");

        // R3 writes with bit0 clear ignore flush and level
        push1(8'hC3, "R3");
        wr1(8'h02, "R3");
        wr1(8'hC2, "R3");
        idle("R3");
        check(count == 1, "R3", "count kept", count, 1);
        pop1("R3");
        check(rd_data == 8'hC3, "R3", "byte kept", rd_data, 8'hC3);

        // R12 mode change flushes; R4 level sweep
        push1(8'h11, "R12");
        wr1(8'h01, "R12");
        idle("R12");
        check(count == 0, "R12", "flushed on enable", count, 0);
        for (int s = 0; s < 4; s++) begin
            wr1({2'(s), 6'b000011}, "R5");
            idle("R5");
            for (int i = 0; i < 15; i++) push1(8'(8'h40 + i), "R4");
        end

        // R6 order and depth, R7 overrun, R10 full
        wr1(8'h03, "R5");
        idle("R5");
        for (int i = 0; i < 16; i++) push1(8'(8'h80 + i), "R6");
        check(full == 1'b1, "R10", "full at 16", full, 1);
        push1(8'hEE, "R7");
        check(overrun == 1'b1, "R7", "overrun pulse", overrun, 1);
        idle("R7");
        // R9 push with pop on full: push dropped, pop taken
        step(1'b1, 8'h55, 1'b1, 1'b0, 8'h00, "R9");
        for (int i = 0; i < 4; i++) step(1'b1, 8'(8'h60 + i), 1'b1, 1'b0, 8'h00, "R9");
        for (int i = 0; i < 16; i++) pop1("R6");
        pop1("R8");

        // R5 flush with data, once, then later pushes kept
        for (int i = 0; i < 5; i++) push1(8'(8'h20 + i), "R5");
        wr1(8'h83, "R5");
        step(1'b1, 8'h99, 1'b1, 1'b0, 8'h00, "R5");
        check(count == 0, "R5", "flushed", count, 0);
        for (int i = 0; i < 3; i++) push1(8'(8'h30 + i), "R5");
        repeat (3) idle("R5");
        check(count == 3, "R5", "kept after self-clear", count, 3);

        // R12 disable with data flushes
        wr1(8'h00, "R12");
        idle("R12");
        check(count == 0, "R12", "flushed on disable", count, 0);
        push1(8'h77, "R2");
        pop1("R2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule